// File: doc/BRIEF.md
# Prioritised Multi-Channel Byte Mover with Bus Throttle

This block copies bytes from one address to another on a bus with 8-bit data and 16-bit addresses. It takes bus cycles from the processor to do so. Each channel holds a source pointer, a destination pointer, a byte count and a set of control bits. These are loaded in one cycle through a configuration port. After loading, the channel is armed. An armed channel moves one byte each time it wins the bus while its peripheral request line is high. When its count runs out, the channel disarms and can pulse an interrupt.

One byte takes two bus clocks: a read of the source address, then a write of that data to the destination address. After each write, a global throttle setting inserts idle cycles. During those cycles the bus is left to the processor, so the engine uses at most 100%, 67%, 50% or 25% of the bus. The bus is claimed through a request/grant handshake. Pending channels are served in fixed priority order. A low-power wait input halts every channel except those that were loaded with wait operation enabled.

The controller is a four-state machine:
- ST_IDLE: no transfer is in progress.
- ST_READ: the source read.
- ST_WRITE: the destination write.
- ST_GAP: the throttle idle slots.

Its transitions are:
- launch: ST_IDLE to ST_READ, taken when the grant is high and some channel is eligible.
- fetch-done: ST_READ to ST_WRITE.
- back-to-back: ST_WRITE to ST_READ, taken at the 100% setting when another byte can launch.
- settle: ST_WRITE to ST_IDLE, taken at the 100% setting when no byte can launch.
- throttle: ST_WRITE to ST_GAP.
- hold: ST_GAP to ST_GAP, while idle slots remain.
- resume: ST_GAP to ST_READ, from the last idle slot when a byte can launch.
- rest: ST_GAP to ST_IDLE, from the last idle slot when no byte can launch.

Top module: `dma_engine`

## Requirements
- R1: Every byte transfer is one cycle with `bus_rd` high followed directly by one cycle with `bus_wr` high; the two are never high together.
- R2: During the write cycle, `bus_wdata` equals the `bus_rdata` value presented during the preceding read cycle. The read uses the channel's source pointer and the write uses its destination pointer.
- R3: Pointer modes are applied after each byte, separately for source and destination. Mode 2'b01 increments the pointer, 2'b10 decrements it, and 2'b00 and 2'b11 leave it unchanged.
- R4: A load count of 1 to 255 moves exactly that many bytes, and a count of 0 moves 256 bytes. `ch_active` for the channel drops after its final write.
- R5: With requests held and the grant high, successive reads start every 2, 3, 4 or 8 cycles for `bw_sel` values 2'b00, 2'b01, 2'b10 and 2'b11 respectively.
- R6: No read starts unless `bus_grant` was high in the cycle before. `bus_req` is high in every read and write cycle, and it stays high while an eligible channel waits for a grant.
- R7: Among eligible channels, the lowest-numbered one is served first. When a channel retires, a lower-priority channel may launch in the very next cycle.
- R8: `irq[n]` pulses for exactly one cycle, in the cycle after channel n's final write, and only if the channel was loaded with its interrupt bit set.
- R9: While `cpu_wait` is high, a channel loaded with its wait-enable bit clear moves no bytes and stays armed. A channel loaded with that bit set keeps transferring.
- R10: An armed channel whose `dreq` bit is low moves no bytes and stays armed.
- R11: After reset, `bus_req`, `bus_rd`, `bus_wr`, `ch_active` and `irq` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_load | input | 1 | Load the channel selected by cfg_ch and arm it |
| cfg_ch | input | CHW | Channel number to load |
| cfg_src | input | AW | Initial source pointer |
| cfg_dst | input | AW | Initial destination pointer |
| cfg_cnt | input | CW | Byte count; 0 means 2^CW |
| cfg_smode | input | 2 | Source pointer mode |
| cfg_dmode | input | 2 | Destination pointer mode |
| cfg_ie | input | 1 | Interrupt on completion |
| cfg_wen | input | 1 | Allow transfers during cpu_wait |
| bw_sel | input | 2 | Bandwidth limit select |
| cpu_wait | input | 1 | Processor is in low-power wait |
| dreq | input | NCH | Peripheral transfer requests |
| bus_grant | input | 1 | Bus granted to the engine |
| bus_rdata | input | DW | Read data from the bus |
| bus_req | output | 1 | Bus request |
| bus_addr | output | AW | Bus address |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_wdata | output | DW | Write data |
| ch_active | output | NCH | Channel armed flags |
| irq | output | NCH | Completion interrupt pulses |

## Verification
The two functions that can land in the same cycle are the retirement of one channel on its final write and the launch of the next transfer. At the 100% setting, arbitration runs during that same write cycle. It must leave out the retiring channel and hand the bus to the next channel with no gap. The bench provokes this by arming channel 0 and channel 2 together with their requests raised at the same time. It then judges the exact sequence of read addresses and checks that the read-to-read spacing stays at two cycles across the hand-over.

// File: rtl/dma_pkg.sv
package dma_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_READ,
        ST_WRITE,
        ST_GAP
    } dma_state_e;

    localparam logic [1:0] PM_INC = 2'b01;
    localparam logic [1:0] PM_DEC = 2'b10;

    // idle slots inserted after each write for a bandwidth setting
    function automatic logic [2:0] gap_of(input logic [1:0] bw);
        unique case (bw)
            2'b00:   gap_of = 3'd0;
            2'b01:   gap_of = 3'd1;
            2'b10:   gap_of = 3'd2;
            default: gap_of = 3'd6;
        endcase
    endfunction

endpackage

// File: rtl/dma_chan.sv
module dma_chan
    import dma_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [AW-1:0] src_i,
    input  logic [AW-1:0] dst_i,
    input  logic [CW-1:0] cnt_i,
    input  logic [1:0]    smode_i,
    input  logic [1:0]    dmode_i,
    input  logic          ie_i,
    input  logic          wen_i,
    input  logic          step_i,
    output logic          active_o,
    output logic [AW-1:0] src_o,
    output logic [AW-1:0] dst_o,
    output logic          ie_o,
    output logic          wen_o,
    output logic          last_o
);

    localparam int RW = CW + 1;

    logic [RW-1:0] remain;
    logic [1:0]    smode_q, dmode_q;

    function automatic logic [AW-1:0] advance(input logic [AW-1:0] a, input logic [1:0] m);
        if (m == PM_INC)      advance = a + AW'(1);
        else if (m == PM_DEC) advance = a - AW'(1);
        else                  advance = a;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active_o <= 1'b0;
            src_o    <= '0;
            dst_o    <= '0;
            remain   <= '0;
            smode_q  <= '0;
            dmode_q  <= '0;
            ie_o     <= 1'b0;
            wen_o    <= 1'b0;
        end else if (load_i) begin
            active_o <= 1'b1;
            src_o    <= src_i;
            dst_o    <= dst_i;
            remain   <= (cnt_i == '0) ? (RW'(1) << CW) : RW'(cnt_i);
            smode_q  <= smode_i;
            dmode_q  <= dmode_i;
            ie_o     <= ie_i;
            wen_o    <= wen_i;
        end else if (step_i) begin
            src_o  <= advance(src_o, smode_q);
            dst_o  <= advance(dst_o, dmode_q);
            remain <= remain - RW'(1);
            if (remain == RW'(1)) active_o <= 1'b0;
        end
    end

    assign last_o = (remain == RW'(1));

    // R4: a channel only disarms through its final byte
    a_r4_retire_on_step: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(active_o) |-> $past(step_i));

endmodule

// File: rtl/dma_arb.sv
module dma_arb #(
    parameter int NCH = 4,
    parameter int IW  = 2
) (
    input  logic [NCH-1:0] req_i,
    output logic [NCH-1:0] gnt_o,
    output logic [IW-1:0]  idx_o,
    output logic           any_o
);

    always_comb begin
        gnt_o = '0;
        idx_o = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                gnt_o    = '0;
                gnt_o[i] = 1'b1;
                idx_o    = IW'(i);
            end
        end
    end

    assign any_o = |req_i;

    // R7: at most one winner, and only a requester wins
    always_comb begin
        a_r7_grant_valid: assert ($onehot0(gnt_o) && ((gnt_o & ~req_i) == '0));
    end

endmodule

// File: rtl/dma_engine.sv
module dma_engine
    import dma_pkg::*;
#(
    parameter int NCH = 4,
    parameter int AW  = 16,
    parameter int DW  = 8,
    parameter int CW  = 8,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_load,
    input  logic [CHW-1:0] cfg_ch,
    input  logic [AW-1:0]  cfg_src,
    input  logic [AW-1:0]  cfg_dst,
    input  logic [CW-1:0]  cfg_cnt,
    input  logic [1:0]     cfg_smode,
    input  logic [1:0]     cfg_dmode,
    input  logic           cfg_ie,
    input  logic           cfg_wen,
    input  logic [1:0]     bw_sel,
    input  logic           cpu_wait,
    input  logic [NCH-1:0] dreq,
    input  logic           bus_grant,
    input  logic [DW-1:0]  bus_rdata,
    output logic           bus_req,
    output logic [AW-1:0]  bus_addr,
    output logic           bus_rd,
    output logic           bus_wr,
    output logic [DW-1:0]  bus_wdata,
    output logic [NCH-1:0] ch_active,
    output logic [NCH-1:0] irq
);

    dma_state_e     state, state_nxt;
    logic [CHW-1:0] cur_ch;
    logic [2:0]     gap_cnt;
    logic [2:0]     gap_w;
    logic [DW-1:0]  data_q;

    logic [NCH-1:0] ie_v, wen_v, last_v, step_v, retire, elig, pick_oh;
    logic [AW-1:0]  src_v [NCH];
    logic [AW-1:0]  dst_v [NCH];
    logic [CHW-1:0] pick_idx;
    logic           pick_any, launch;

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        dma_chan #(.AW(AW), .CW(CW)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .load_i   (cfg_load && (cfg_ch == CHW'(g))),
            .src_i    (cfg_src),
            .dst_i    (cfg_dst),
            .cnt_i    (cfg_cnt),
            .smode_i  (cfg_smode),
            .dmode_i  (cfg_dmode),
            .ie_i     (cfg_ie),
            .wen_i    (cfg_wen),
            .step_i   (step_v[g]),
            .active_o (ch_active[g]),
            .src_o    (src_v[g]),
            .dst_o    (dst_v[g]),
            .ie_o     (ie_v[g]),
            .wen_o    (wen_v[g]),
            .last_o   (last_v[g])
        );
    end

    // a channel retiring in this write cycle must not win the next slot
    always_comb begin
        step_v = '0;
        retire = '0;
        if (state == ST_WRITE) begin
            step_v[cur_ch] = 1'b1;
            retire[cur_ch] = last_v[cur_ch];
        end
    end

    assign elig = ch_active & dreq & ({NCH{~cpu_wait}} | wen_v) & ~retire;

    dma_arb #(.NCH(NCH), .IW(CHW)) u_arb (
        .req_i (elig),
        .gnt_o (pick_oh),
        .idx_o (pick_idx),
        .any_o (pick_any)
    );

    assign gap_w  = gap_of(bw_sel);
    assign launch = bus_grant && pick_any;

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:  state_nxt = launch ? ST_READ : ST_IDLE;
            ST_READ:  state_nxt = ST_WRITE;
            ST_WRITE: state_nxt = (gap_w != 3'd0) ? ST_GAP
                                : (launch ? ST_READ : ST_IDLE);
            ST_GAP:   state_nxt = (gap_cnt != 3'd1) ? ST_GAP
                                : (launch ? ST_READ : ST_IDLE);
            default:  state_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cur_ch  <= '0;
            gap_cnt <= '0;
            data_q  <= '0;
            irq     <= '0;
        end else begin
            state <= state_nxt;
            if (state_nxt == ST_READ) cur_ch <= pick_idx;
            if (state == ST_WRITE)    gap_cnt <= gap_w;
            else if (state == ST_GAP) gap_cnt <= gap_cnt - 3'd1;
            if (state == ST_READ)     data_q <= bus_rdata;
            irq <= retire & ie_v;
        end
    end

    always_comb begin
        bus_rd    = 1'b0;
        bus_wr    = 1'b0;
        bus_addr  = '0;
        bus_wdata = data_q;
        bus_req   = 1'b0;
        unique case (state)
            ST_IDLE:  bus_req = pick_any;
            ST_READ: begin
                bus_req  = 1'b1;
                bus_rd   = 1'b1;
                bus_addr = src_v[cur_ch];
            end
            ST_WRITE: begin
                bus_req  = 1'b1;
                bus_wr   = 1'b1;
                bus_addr = dst_v[cur_ch];
            end
            ST_GAP:   bus_req = (gap_cnt == 3'd1) && pick_any;
            default:  bus_req = 1'b0;
        endcase
    end

    // R1: a read is always followed directly by its write
    a_r1_read_then_write: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> bus_wr);
    a_r1_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr));
    // R2: write data is the byte captured during the read
    a_r2_data_carried: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> (bus_wdata == $past(bus_rdata)));
    // R5: throttled settings leave the cycle after a write idle
    a_r5_gap_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bw_sel != 2'b00) |=> !bus_rd);
    // R6: a read begins only after a granted cycle
    a_r6_read_granted: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_rd) |-> $past(bus_grant));
    // R8: single-channel, single-cycle interrupt right after a write
    a_r8_irq_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(irq));
    a_r8_irq_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq) |-> $past(bus_wr));

endmodule

// File: tb/dma_engine_bench.sv
module dma_engine_bench;

    localparam int NCH = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           cfg_load = 1'b0;
    logic [1:0]     cfg_ch = '0;
    logic [15:0]    cfg_src = '0, cfg_dst = '0;
    logic [7:0]     cfg_cnt = '0;
    logic [1:0]     cfg_smode = '0, cfg_dmode = '0;
    logic           cfg_ie = 1'b0, cfg_wen = 1'b0;
    logic [1:0]     bw_sel = '0;
    logic           cpu_wait = 1'b0;
    logic [NCH-1:0] dreq = '0;
    logic           bus_grant = 1'b1;
    logic [7:0]     bus_rdata;
    logic           bus_req, bus_rd, bus_wr;
    logic [15:0]    bus_addr;
    logic [7:0]     bus_wdata;
    logic [NCH-1:0] ch_active, irq;

    int seed = 0;
    int cyc = 0;
    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [7:0] pat(input logic [15:0] a, input int s);
        return 8'((int'(a[9:0]) * 7 + s) & 255);
    endfunction

    function automatic logic [15:0] nxt(input logic [15:0] a, input int m);
        if (m == 1) return a + 16'd1;
        if (m == 2) return a - 16'd1;
        return a;
    endfunction

    assign bus_rdata = pat(bus_addr, seed);

    dma_engine #(.NCH(NCH)) u_dma_engine (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_ch(cfg_ch),
        .cfg_src(cfg_src), .cfg_dst(cfg_dst), .cfg_cnt(cfg_cnt),
        .cfg_smode(cfg_smode), .cfg_dmode(cfg_dmode), .cfg_ie(cfg_ie),
        .cfg_wen(cfg_wen), .bw_sel(bw_sel), .cpu_wait(cpu_wait), .dreq(dreq),
        .bus_grant(bus_grant), .bus_rdata(bus_rdata), .bus_req(bus_req),
        .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .ch_active(ch_active), .irq(irq)
    );

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", rq, act, exp, cyc);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    task automatic load_ch(input int ch, input logic [15:0] s, input logic [15:0] d,
                           input int cnt, input int sm, input int dm,
                           input bit ie, input bit wen);
        @(negedge clk);
        cfg_ch = 2'(ch); cfg_src = s; cfg_dst = d; cfg_cnt = 8'(cnt);
        cfg_smode = 2'(sm); cfg_dmode = 2'(dm); cfg_ie = ie; cfg_wen = wen;
        cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
    endtask

    // one channel, continuous request: checks R1..R6 and R8 per byte
    task automatic run_block(input int ch, input int bw, input int sm, input int dm,
                             input int cnt, input bit ie);
        logic [15:0] sa = 16'h5100, da = 16'hA300;
        int n = (cnt == 0) ? 256 : cnt;
        int gap = (bw == 3) ? 6 : bw;
        int prev = -1, nw = 0, nirq = 0;
        bit pend = 1'b0;
        seed = seed + 13;
        bw_sel = 2'(bw);
        load_ch(ch, sa, da, cnt, sm, dm, ie, 1'b0);
        dreq[ch] = 1'b1;
        for (int t = 0; t < 3000 && ch_active[ch]; t++) begin
            @(negedge clk);
            if (bus_rd) begin
                chk(bus_addr == sa, "R3 src addr", bus_addr, sa);
                chk(bus_req, "R6 req in read", bus_req, 1);
                if (prev >= 0) chk(cyc - prev == 2 + gap, "R5 spacing", cyc - prev, 2 + gap);
                prev = cyc;
                pend = 1'b1;
            end
            if (bus_wr) begin
                chk(pend, "R1 write after read", pend, 1);
                chk(bus_addr == da, "R3 dst addr", bus_addr, da);
                chk(bus_wdata == pat(sa, seed), "R2 data", bus_wdata, pat(sa, seed));
                sa = nxt(sa, sm);
                da = nxt(da, dm);
                nw++;
                pend = 1'b0;
            end
            if (irq[ch]) nirq++;
        end
        dreq[ch] = 1'b0;
        for (int t = 0; t < 3; t++) begin
            @(negedge clk);
            if (irq[ch]) nirq++;
        end
        chk(nw == n, "R4 byte count", nw, n);
        chk(!ch_active[ch], "R4 disarmed", ch_active[ch], 0);
        chk(nirq == int'(ie), "R8 irq pulses", nirq, int'(ie));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!bus_req && !bus_rd && !bus_wr, "R11 strobes in reset", {bus_req, bus_rd, bus_wr}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ch_active == '0 && irq == '0 && !bus_req, "R11 after reset",
            {ch_active, irq, bus_req}, 0);

        // sweep: every throttle setting against every pointer-mode pair
        for (int bw = 0; bw < 4; bw++)
            for (int sm = 0; sm < 4; sm++)
                for (int dm = 0; dm < 4; dm++)
                    run_block((sm + dm) % NCH, bw, sm, dm, (bw * 16 + sm * 4 + dm) % 7 + 2,
                              1'((sm + bw) % 2));

        // count boundaries: R4 (0 means 256, 255, 1)
        run_block(0, 0, 1, 1, 0, 1'b1);
        run_block(3, 1, 2, 1, 255, 1'b0);
        run_block(2, 3, 1, 2, 1, 1'b1);

        // R7: channels 0 and 2 together, hand-over in the retire cycle
        begin
            logic [15:0] exp_a [6];
            int nr = 0, prev = -1;
            exp_a = '{16'h5100, 16'h5101, 16'h5102, 16'h5140, 16'h5141, 16'h5142};
            bw_sel = 2'b00;
            load_ch(2, 16'h5140, 16'hA340, 3, 1, 1, 1'b0, 1'b0);
            load_ch(0, 16'h5100, 16'hA300, 3, 1, 1, 1'b0, 1'b0);
            dreq = 4'b0101;
            for (int t = 0; t < 100 && (ch_active[0] || ch_active[2]); t++) begin
                @(negedge clk);
                if (bus_rd) begin
                    if (nr < 6) chk(bus_addr == exp_a[nr], "R7 order", bus_addr, exp_a[nr]);
                    if (prev >= 0) chk(cyc - prev == 2, "R7 no gap at hand-over", cyc - prev, 2);
                    prev = cyc;
                    nr++;
                end
            end
            chk(nr == 6, "R7 total reads", nr, 6);
            dreq = '0;
        end

        // R6: grant withheld
        begin
            bit seen = 1'b0;
            load_ch(1, 16'h5100, 16'hA300, 2, 1, 1, 1'b0, 1'b0);
            bus_grant = 1'b0;
            dreq[1] = 1'b1;
            repeat (16) begin
                @(negedge clk);
                if (bus_rd) seen = 1'b1;
            end
            chk(!seen, "R6 no read without grant", seen, 0);
            chk(bus_req, "R6 request held", bus_req, 1);
            bus_grant = 1'b1;
            for (int t = 0; t < 50 && ch_active[1]; t++) @(negedge clk);
            chk(!ch_active[1], "R6 completes after grant", ch_active[1], 0);
            dreq = '0;
        end

        // R10: armed channel without request
        begin
            bit seen = 1'b0;
            load_ch(3, 16'h5100, 16'hA300, 2, 1, 1, 1'b0, 1'b0);
            repeat (16) begin
                @(negedge clk);
                if (bus_rd) seen = 1'b1;
            end
            chk(!seen, "R10 no read without dreq", seen, 0);
            chk(ch_active[3], "R10 stays armed", ch_active[3], 1);
            dreq[3] = 1'b1;
            for (int t = 0; t < 50 && ch_active[3]; t++) @(negedge clk);
            chk(!ch_active[3], "R10 completes with dreq", ch_active[3], 0);
            dreq = '0;
        end

        // R9: wait mode halts only channels without wait enable
        begin
            bit seen = 1'b0;
            cpu_wait = 1'b1;
            load_ch(1, 16'h5100, 16'hA300, 2, 1, 1, 1'b0, 1'b0);
            dreq[1] = 1'b1;
            repeat (16) begin
                @(negedge clk);
                if (bus_rd) seen = 1'b1;
            end
            chk(!seen, "R9 halted in wait", seen, 0);
            load_ch(3, 16'h5140, 16'hA340, 2, 1, 1, 1'b0, 1'b1);
            dreq[3] = 1'b1;
            for (int t = 0; t < 50 && ch_active[3]; t++) @(negedge clk);
            chk(!ch_active[3], "R9 wait-enabled runs", ch_active[3], 0);
            chk(ch_active[1], "R9 other still armed", ch_active[1], 1);
            cpu_wait = 1'b0;
            for (int t = 0; t < 50 && ch_active[1]; t++) @(negedge clk);
            chk(!ch_active[1], "R9 resumes after wait", ch_active[1], 0);
            dreq = '0;
        end

        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule